// File: doc/BRIEF.md
# Circular Event Queue Writer with Generation Marking

This block appends event words to a circular queue that lives in system memory. It holds the per-queue state: base address, size code, write index, a generation bit and a sticky flipped flag. A producer offers an event with a valid/ready handshake. The block turns the lower 31 bits of the event into one 32-bit stored word, and places the current generation bit on top. It then issues a single word write to memory and waits for that write's response.

On a successful write the index moves forward modulo the queue length. Each time the index returns to zero, the generation bit inverts. A consumer polling the queue can tell fresh entries from stale ones by the top bit alone, so it needs no shared read pointer. On an error response the queue state stays as it was and a sticky error flag rises. The base and size are loaded through a configuration strobe, which is only taken while no write is in flight.

Top module: `eq_writer`

## Requirements
- R1: While reset is held and after it is released, the write index, generation bit, flipped flag and error flag are all zero, req_ready is high and mem_wr_valid is low.
- R2: A cfg_load pulse while idle loads cfg_base and cfg_size into st_base and st_size and sets the index to zero, leaving the generation bit and flipped flag unchanged. In the same cycle req_ready is low.
- R3: A cfg_load while a write is outstanding has no effect on base, size or index.
- R4: mem_wr_addr equals base + 4 × index, taken modulo 2^32, where the index is its value when the event was accepted.
- R5: The stored word is {generation, data[30:0]}, and data bit 31 is dropped. It is presented big-endian on mem_wr_data: bits [7:0] (the lowest byte address) carry word bits [31:24], and bits [31:24] carry word bits [7:0].
- R6: An event is accepted on a clock edge where req_valid and req_ready are both high. From the next cycle, mem_wr_valid stays high with a steady address and data until the edge where mem_rsp_valid is seen. req_ready stays low for all of that time, so only one write is outstanding.
- R7: After a response with mem_rsp_err low, the index becomes (index + 1) mod 2^(size + 10).
- R8: When a successful write moves the index to zero, the generation bit inverts and the flipped flag takes the new generation value. At no other time does the generation bit change.
- R9: After a response with mem_rsp_err high, the index and generation bit are unchanged and st_error goes high. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load base and size, idle only |
| cfg_base | input | 32 | Queue base byte address |
| cfg_size | input | 3 | Size code; length is 2^(code+10) words |
| req_valid | input | 1 | Event offered |
| req_ready | output | 1 | Block can accept an event |
| req_data | input | 32 | Event payload; bit 31 ignored |
| mem_wr_valid | output | 1 | Word write request, held until response |
| mem_wr_addr | output | 32 | Byte address of the word |
| mem_wr_data | output | 32 | Stored word in big-endian byte lanes |
| mem_rsp_valid | input | 1 | Write response strobe |
| mem_rsp_err | input | 1 | Write failed, qualified by mem_rsp_valid |
| st_base | output | 32 | Current base address |
| st_size | output | 3 | Current size code |
| st_index | output | 17 | Current write index |
| st_gen | output | 1 | Current generation bit |
| st_flipped | output | 1 | Value of generation at last wrap |
| st_error | output | 1 | Sticky write-error flag |

## Verification
The bench drives the smallest queue through two full wraps. This shows the generation and flipped flag going to one and back to zero. A design that tested for the wrap before masking, or that flipped at the last entry instead of at index zero, would show the wrong top bit on entry 0 of the second pass. Error responses land in the middle of a run to show that a failed write leaves index and generation alone. A design that advanced anyway would leave a hole in the queue. A configuration pulse is sent during an outstanding write and must be dropped, and a base near the top of the address space checks that address arithmetic wraps cleanly. The payload is given bit 31 set so that a design leaking it, or presenting the word little-endian, is exposed on the data lanes.

// File: rtl/eqw_pkg.sv
package eqw_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_N = WORD_W / 8;

  typedef enum logic [0:0] {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xfer_state_t;

  // Word as seen by the consumer: generation on top, payload below.
  function automatic logic [WORD_W-1:0] mark_word(input logic gen,
                                                  input logic [WORD_W-2:0] payload);
    return {gen, payload};
  endfunction

  // Reorder a word so its most significant byte sits in lane 0 (lowest address).
  function automatic logic [WORD_W-1:0] to_big_lanes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < BYTE_N; k++) begin
      r[8*k +: 8] = w[8*(BYTE_N-1-k) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/eqw_cfg.sv
module eqw_cfg #(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              busy,
  output logic [ADDR_W-1:0] base_q,
  output logic [SZ_W-1:0]   size_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (take) begin
      base_q <= base_i;
      size_q <= size_i;
    end
  end

  // R3: nothing reaches the registers while a write is outstanding
  p_cfg_frozen_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_q) && $stable(size_q)));

endmodule

// File: rtl/eqw_ptr.sv
module eqw_ptr #(
  parameter int SZ_W  = 3,
  parameter int IDX_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [SZ_W-1:0]  size_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             gen_q,
  output logic             flip_q,
  output logic             wrap_o
);

  // Mask of valid index bits for a queue of 2^(code+10) entries.
  function automatic logic [IDX_W-1:0] len_mask(input logic [SZ_W-1:0] code);
    logic [IDX_W-1:0] m;
    for (int b = 0; b < IDX_W; b++) begin
      m[b] = (b < (int'(code) + 10));
    end
    return m;
  endfunction

  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    idx_nxt = (idx_q + IDX_W'(1)) & len_mask(size_q);
    wrap_o  = step && (idx_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      gen_q  <= 1'b0;
      flip_q <= 1'b0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= idx_nxt;
      if (wrap_o) begin
        gen_q  <= ~gen_q;
        flip_q <= ~gen_q;
      end
    end
  end

  // R8: generation only moves when the index lands on zero
  p_gen_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_q) |-> (idx_q == '0));

  // R8: flipped flag mirrors the generation it produced
  p_flip_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_q) |-> (flip_q == gen_q));

  // R7: index never leaves the configured window
  p_idx_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q & ~len_mask(size_q)) == '0);

  // R7: a successful write always moves the index
  p_step_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (idx_q != $past(idx_q)));

endmodule

// File: rtl/eqw_xfer.sv
module eqw_xfer
  import eqw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_data,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic              gen_q,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              idle_o,
  output logic              done_ok_o,
  output logic              err_q
);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + (ADDR_W'(idx) << 2);
  endfunction

  xfer_state_t      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              accept;
  logic              rsp_fire;

  always_comb begin
    idle_o    = (st_q == XS_IDLE);
    req_ready = idle_o && !cfg_load;
    accept    = req_ready && req_valid;
    rsp_fire  = (st_q == XS_WAIT) && mem_rsp_valid;
    done_ok_o = rsp_fire && !mem_rsp_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        XS_IDLE: if (accept) begin
          st_q   <= XS_WAIT;
          addr_q <= slot_addr(base_q, idx_q);
          data_q <= to_big_lanes(mark_word(gen_q, req_data[WORD_W-2:0]));
        end
        XS_WAIT: if (mem_rsp_valid) begin
          st_q <= XS_IDLE;
          if (mem_rsp_err) err_q <= 1'b1;
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign mem_wr_valid = (st_q == XS_WAIT);
  assign mem_wr_addr  = addr_q;
  assign mem_wr_data  = data_q;

  // R6: never a second acceptance while one write is in flight
  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !req_ready);

  // R6: request held steady until its response
  p_hold_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_rsp_valid) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R6: acceptance launches a write on the next cycle
  p_accept_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_wr_valid);

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/eq_writer.sv
module eq_writer
  import eqw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 3,
  localparam int IDX_W = (1 << SZ_W) - 1 + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic [ADDR_W-1:0] st_base,
  output logic [SZ_W-1:0]   st_size,
  output logic [IDX_W-1:0]  st_index,
  output logic              st_gen,
  output logic              st_flipped,
  output logic              st_error
);

  logic idle;
  logic cfg_take;
  logic step_ok;
  logic wrap_evt;

  assign cfg_take = cfg_load && idle;

  eqw_cfg #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (cfg_take),
    .base_i (cfg_base),
    .size_i (cfg_size),
    .busy   (!idle),
    .base_q (st_base),
    .size_q (st_size)
  );

  eqw_ptr #(.SZ_W(SZ_W), .IDX_W(IDX_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cfg_take),
    .step   (step_ok),
    .size_q (st_size),
    .idx_q  (st_index),
    .gen_q  (st_gen),
    .flip_q (st_flipped),
    .wrap_o (wrap_evt)
  );

  eqw_xfer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_xfer (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .req_valid     (req_valid),
    .req_data      (req_data),
    .req_ready     (req_ready),
    .base_q        (st_base),
    .idx_q         (st_index),
    .gen_q         (st_gen),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .idle_o        (idle),
    .done_ok_o     (step_ok),
    .err_q         (st_error)
  );

  // R9: a failed write leaves the queue position alone
  p_err_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_rsp_valid && mem_rsp_err) |=>
      ($stable(st_index) && $stable(st_gen) && st_error));

  // R4: address is base plus word offset of the live index
  p_addr_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr == st_base + ADDR_W'(st_index) * ADDR_W'(4)));

  // R2: idle configuration restarts the index
  p_cfg_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !mem_wr_valid) |=> (st_index == '0 && !req_ready || st_index == '0));

  // R8: wrap event is visible on the generation output next cycle
  p_wrap_flips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (st_gen != $past(st_gen)));

endmodule

// File: tb/tb_eq_writer.sv
module tb_eq_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_size = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_data = '0;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] st_base;
  logic [2:0]  st_size;
  logic [16:0] st_index;
  logic        st_gen, st_flipped, st_error;

  always #5 clk = ~clk;

  eq_writer dut (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_base = 0;
  int          m_size = 0;
  int          m_idx = 0;
  bit          m_gen = 0, m_flip = 0, m_err = 0, m_busy = 0;
  logic [31:0] m_addr = 0;
  logic [31:0] m_word = 0;

  // responder controls
  int rsp_lat = 0;
  int lat_cnt = 0;
  bit err_mode = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_size = 0; m_idx = 0; m_gen = 0; m_flip = 0; m_err = 0; m_busy = 0;
    end else if (!m_busy) begin
      if (cfg_load) begin
        m_base = cfg_base; m_size = cfg_size; m_idx = 0;
      end else if (req_valid) begin
        m_busy = 1;
        m_addr = m_base + 32'(m_idx * 4);
        m_word = req_data;
        m_word[31] = m_gen;
      end
    end else if (mem_rsp_valid) begin
      m_busy = 0;
      if (mem_rsp_err) m_err = 1;
      else begin
        m_idx = (m_idx + 1) % (1 << (m_size + 10));
        if (m_idx == 0) begin
          m_gen = !m_gen;
          m_flip = m_gen;
        end
      end
    end
  end

  function automatic logic [31:0] lanes_of(input logic [31:0] w);
    logic [31:0] r = '0;
    for (int lane = 0; lane < 4; lane++) begin
      r[lane*8 +: 8] = w[31 - lane*8 -: 8];
    end
    return r;
  endfunction

  // per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && !finished) begin
        check("R6 req_ready", req_ready, !m_busy && !cfg_load);
        check("R6 mem_wr_valid", mem_wr_valid, m_busy);
        if (m_busy) begin
          check("R4 mem_wr_addr", mem_wr_addr, m_addr);
          check("R5 mem_wr_data", mem_wr_data, lanes_of(m_word));
        end
        check("R7 st_index", st_index, m_idx);
        check("R8 st_gen", st_gen, m_gen);
        check("R8 st_flipped", st_flipped, m_flip);
        check("R9 st_error", st_error, m_err);
        check("R2 st_base", st_base, m_base);
        check("R2 st_size", st_size, m_size);
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_wr_valid) begin
        if (lat_cnt >= rsp_lat) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_err = err_mode;
          lat_cnt = 0;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  // entered at a negedge, leaves at a negedge with the write finished
  task automatic send(input logic [31:0] d, input int lat);
    bit got = 0;
    rsp_lat = lat;
    req_valid = 1'b1;
    req_data = d;
    while (!got) begin
      #1 got = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (mem_wr_valid) @(negedge clk);
  endtask

  task automatic configure(input logic [31:0] b, input logic [2:0] s);
    cfg_load = 1'b1; cfg_base = b; cfg_size = s;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: outputs under reset
    check("R1 index in reset", st_index, 0);
    check("R1 ready in reset", req_ready, 1);
    check("R1 wr_valid in reset", mem_wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R1 gen after reset", st_gen, 0);
    check("R1 flipped after reset", st_flipped, 0);
    check("R1 error after reset", st_error, 0);
    @(negedge clk);

    configure(32'h1000_0000, 3'd0);
    check("R2 base loaded", st_base, 32'h1000_0000);
    for (int i = 0; i < 6; i++) begin
      send(32'h8000_0000 | (32'hA5 << i) | i, i % 3);
    end
    check("R7 index after six", st_index, 6);

    // R9: error responses leave the position alone
    err_mode = 1;
    send(32'hDEAD_BEEF, 1);
    send(32'h1234_5678, 0);
    err_mode = 0;
    check("R9 index held on error", st_index, 6);
    check("R9 error sticky", st_error, 1);

    // R8: run through two wraps of a 1024-entry queue
    for (int i = 6; i < 1024; i++) send(32'(i * 7), 0);
    check("R8 gen after first wrap", st_gen, 1);
    check("R8 flipped after first wrap", st_flipped, 1);
    check("R8 index at wrap", st_index, 0);
    send(32'hFFFF_FFFF, 1);
    check("R5 gen bit shows in lane 0", mem_wr_data, 32'hFFFF_FFFF);
    for (int i = 1; i < 1024; i++) send(32'(i), 0);
    check("R8 gen after second wrap", st_gen, 0);
    check("R8 flipped after second wrap", st_flipped, 0);

    // R3: configuration during an outstanding write is dropped
    rsp_lat = 4;
    req_valid = 1'b1; req_data = 32'h0000_0042;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_load = 1'b1; cfg_base = 32'h2222_0000; cfg_size = 3'd5;
    @(negedge clk);
    cfg_load = 1'b0;
    while (mem_wr_valid) @(negedge clk);
    check("R3 base unchanged", st_base, 32'h1000_0000);
    check("R3 size unchanged", st_size, 0);
    check("R3 index advanced normally", st_index, 1);

    // R2/R4: new queue near top of address space
    configure(32'hFFFF_FFF0, 3'd2);
    check("R2 index restarted", st_index, 0);
    check("R2 gen kept", st_gen, 0);
    for (int i = 0; i < 6; i++) send(32'h7000_0000 + 32'(i), 1);
    check("R7 index in larger queue", st_index, 6);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule